// File: doc/BRIEF.md
# Repeating Status Byte Responder

This block is the device side of a serial peripheral link that answers one command: a status query. The host lowers the select line, shifts in one command byte, and then keeps clocking. When the byte matches the status-query code, the block returns an 8-bit status word on the data-out line, most significant bit first. It keeps returning that word for as long as select stays low and the serial clock keeps running.

Each new copy of the word is rebuilt from live status at the moment the previous copy finishes. A host can therefore poll the ready/busy flag without reissuing the command. Any other command byte makes the block stay silent until select is released.

All serial inputs are brought into the block's system clock domain through synchronizer stages. Serial clock edges are found by comparing successive synchronized samples. The data-out line is driven only while a status stream is active; at all other times the output-enable is low.

Top module: `stat_resp`

## Requirements
- R1: Only the command byte 8'hD7, shifted in MSB first on serial-clock rising edges, starts a status stream (output enable goes high); any other byte leaves the output disabled.
- R2: The first status bit (bit 7) appears on data-out after the first serial-clock falling edge that follows the command's eighth rising edge. The remaining bits follow MSB first, one per falling edge.
- R3: After eight status bits the word repeats for as long as select stays low. Each repetition is rebuilt from the status inputs as they stand at the rising edge that completes the previous word.
- R4: Bit 7 of the word is 1 when ready and 0 when busy. Bit 6 is the compare-result flag, where 0 means match and 1 means mismatch.
- R5: Bits 5..2 of the word always carry the fixed code 4'b1001.
- R6: Bit 1 is 1 when sector protection is on. Bit 0 is 1 for the 256-byte page mode and 0 for the 264-byte page mode.
- R7: After a byte other than 8'hD7, further clocking in the same selection leaves output enable low and data-out at 0.
- R8: Raising select disables the output, drives data-out to 0 and clears the bit counters, so a partial byte has no effect on the next selection.
- R9: A status query is answered while the ready input is low (busy).
- R10: After reset, and whenever the output is disabled, data-out is 0.
- R11: A status change in the middle of a word does not alter that word; it first shows in the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host (idle low) |
| spi_cs_n | input | 1 | Select, active low |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| spi_miso_oe | output | 1 | Output enable for spi_miso (tri-state control) |
| st_ready | input | 1 | 1 = device ready, 0 = busy |
| st_mismatch | input | 1 | Latest compare result, 1 = mismatch |
| st_protect | input | 1 | 1 = sector protection enabled |
| st_page256 | input | 1 | 1 = 256-byte page mode |

## Verification
Two opposite status settings (ready with protection and 264-byte pages, then busy with mismatch and 256-byte pages) give words in which every variable bit takes both values, so a swapped or stuck field shows up. A stream of several words, with the status changed in the middle of one word, separates per-word reloading from a one-time snapshot and from reloading at the wrong edge. Near-miss and unrelated command bytes test that the block stays silent. A selection aborted after three bits tests that releasing select clears the bit counter.

// File: rtl/stat_resp_pkg.sv
package stat_resp_pkg;

  localparam int WORD_W = 8;

  typedef enum logic [1:0] {
    PH_OPCODE = 2'd0,
    PH_STREAM = 2'd1,
    PH_IGNORE = 2'd2
  } phase_e;

  // Word layout: ready, mismatch, fixed code[3:0], protect, page256
  function automatic logic [WORD_W-1:0] pack_status(
    input logic       ready,
    input logic       mismatch,
    input logic [3:0] code,
    input logic       protect,
    input logic       page256
  );
    return {ready, mismatch, code, protect, page256};
  endfunction

endpackage

// File: rtl/stat_resp_sync.sv
module stat_resp_sync #(
  parameter int             W       = 3,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);

  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= RST_VAL;
    end else begin
      chain_q[0] <= d_in;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_out = chain_q[STAGES-1];

endmodule

// File: rtl/stat_resp_rx.sv
module stat_resp_rx
  import stat_resp_pkg::*;
#(
  parameter logic [WORD_W-1:0] OPCODE = 8'hD7
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sel,
  input  logic   sck_rise,
  input  logic   mosi_s,
  output phase_e phase,
  output logic   start
);

  localparam int                CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0]  LAST  = CNT_W'(WORD_W - 1);

  phase_e              phase_q, phase_d;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [WORD_W-1:0]   byte_q, byte_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    byte_d  = byte_q;
    start   = 1'b0;
    if (!sel) begin
      phase_d = PH_OPCODE;
      cnt_d   = '0;
    end else if (sck_rise && phase_q == PH_OPCODE) begin
      byte_d = {byte_q[WORD_W-2:0], mosi_s};
      if (cnt_q == LAST) begin
        cnt_d = '0;
        if (byte_d == OPCODE) begin
          phase_d = PH_STREAM;
          start   = 1'b1;
        end else begin
          phase_d = PH_IGNORE;
        end
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OPCODE;
      cnt_q   <= '0;
      byte_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      byte_q  <= byte_d;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/stat_resp_tx.sv
module stat_resp_tx
  import stat_resp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              start,
  input  logic              streaming,
  input  logic [WORD_W-1:0] status_in,
  output logic              miso,
  output logic              miso_oe,
  output logic              reload
);

  localparam int               CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              so_q, so_d;
  logic              oe_q, oe_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    so_d   = so_q;
    oe_d   = oe_q;
    reload = 1'b0;
    if (start) begin
      sh_d   = status_in;
      cnt_d  = '0;
      so_d   = 1'b0;
      oe_d   = 1'b1;
      reload = 1'b1;
    end else if (!streaming || !sel) begin
      cnt_d = '0;
      so_d  = 1'b0;
      oe_d  = 1'b0;
    end else begin
      if (sck_fall) begin
        so_d = sh_q[WORD_W-1];
        sh_d = {sh_q[WORD_W-2:0], 1'b0};
      end
      if (sck_rise) begin
        if (cnt_q == LAST) begin
          cnt_d  = '0;
          sh_d   = status_in;
          reload = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      so_q  <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      so_q  <= so_d;
      oe_q  <= oe_d;
    end
  end

  assign miso    = so_q;
  assign miso_oe = oe_q;

endmodule

// File: rtl/stat_resp.sv
module stat_resp
  import stat_resp_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [WORD_W-1:0] OPCODE      = 8'hD7,
  parameter logic [3:0]        CODE        = 4'b1001
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sck,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  output logic spi_miso_oe,
  input  logic st_ready,
  input  logic st_mismatch,
  input  logic st_protect,
  input  logic st_page256
);

  logic [2:0]        pins_s;
  logic              sck_prev_q;
  logic              sel, sck_rise, sck_fall, start, reload, streaming;
  phase_e            phase;
  logic [WORD_W-1:0] status_word;

  // {cs_n, sck, mosi}; select idles high
  stat_resp_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_in ({spi_cs_n, spi_sck, spi_mosi}),
    .q_out(pins_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_prev_q <= 1'b0;
    else        sck_prev_q <= pins_s[1];
  end

  assign sel       = !pins_s[2];
  assign sck_rise  = pins_s[1] & !sck_prev_q;
  assign sck_fall  = !pins_s[1] & sck_prev_q;
  assign streaming = (phase == PH_STREAM);

  assign status_word = pack_status(st_ready, st_mismatch, CODE, st_protect, st_page256);

  stat_resp_rx #(.OPCODE(OPCODE)) u_rx (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .sck_rise(sck_rise),
    .mosi_s  (pins_s[0]),
    .phase   (phase),
    .start   (start)
  );

  stat_resp_tx u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .start    (start),
    .streaming(streaming),
    .status_in(status_word),
    .miso     (spi_miso),
    .miso_oe  (spi_miso_oe),
    .reload   (reload)
  );

endmodule

// File: rtl/stat_resp_chk.sv
module stat_resp_chk (
  input logic clk,
  input logic rst_n,
  input logic sel,
  input logic sck_rise,
  input logic sck_fall,
  input logic start,
  input logic reload,
  input logic miso,
  input logic miso_oe
);

  // R1: the output is enabled only after the receiver accepted the command
  a_r1_enable_after_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(start));

  // R8: a released select turns the output off on the next cycle
  a_r8_deselect_quiets: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso_oe);

  // R10: disabled output always rests at 0
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !miso_oe |-> !miso);

  // R2: data-out moves only after a falling edge or a deselect
  a_r2_shift_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(miso) |-> ($past(sck_fall) || !$past(sel)));

  // R3: a new word is loaded only at command end or on a rising edge
  a_r3_reload_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    reload |-> (start || sck_rise));

endmodule

bind stat_resp stat_resp_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sel     (sel),
  .sck_rise(sck_rise),
  .sck_fall(sck_fall),
  .start   (start),
  .reload  (reload),
  .miso    (spi_miso),
  .miso_oe (spi_miso_oe)
);

// File: tb/sim_stat_resp.sv
`timescale 1ns/1ps
module sim_stat_resp;

  logic clk = 1'b0;
  logic rst_n;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso, spi_miso_oe;
  logic st_ready, st_mismatch, st_protect, st_page256;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] exp_word;

  always #5 clk = ~clk;

  stat_resp u0 (
    .clk(clk), .rst_n(rst_n),
    .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
    .st_ready(st_ready), .st_mismatch(st_mismatch),
    .st_protect(st_protect), .st_page256(st_page256)
  );

  // Reference word built from the requirement text (R4, R5, R6)
  function automatic logic [7:0] model_word();
    return {st_ready, st_mismatch, 4'b1001, st_protect, st_page256};
  endfunction

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual oe/miso=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_status(input logic [3:0] s);
    {st_ready, st_mismatch, st_protect, st_page256} = s;
  endtask

  // One SCK period: drive data, low phase, optional sample, high phase
  task automatic do_bit(input logic mo, input bit chk, input logic exp_oe,
                        input logic exp_bit, input string req);
    spi_mosi = mo;
    repeat (8) @(negedge clk);
    if (chk) check(req, {spi_miso_oe, spi_miso}, {exp_oe, exp_bit});
    spi_sck = 1'b1;
    repeat (8) @(negedge clk);
    spi_sck = 1'b0;
  endtask

  task automatic select_on();
    spi_cs_n = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic select_off();
    repeat (8) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (8) @(negedge clk);
    check("R8 release", {spi_miso_oe, spi_miso}, 2'b00);
  endtask

  task automatic send_cmd(input logic [7:0] op);
    for (int i = 7; i >= 0; i--) do_bit(op[i], 1'b0, 1'b0, 1'b0, "");
    exp_word = model_word();
  endtask

  task automatic stream(input int nwords, input int chg_word, input int chg_bit,
                        input logic [3:0] ns, input string req);
    for (int w = 0; w < nwords; w++) begin
      for (int i = 0; i < 8; i++) begin
        if (w == chg_word && i == chg_bit) set_status(ns);
        do_bit(1'b0, 1'b1, 1'b1, exp_word[7-i], req);
      end
      exp_word = model_word();
    end
  endtask

  task automatic silent(input int nwords);
    for (int w = 0; w < nwords; w++)
      for (int i = 0; i < 8; i++) do_bit(i[0], 1'b1, 1'b0, 1'b0, "R7 ignored");
  endtask

  initial begin
    rst_n = 1'b0; spi_cs_n = 1'b1; spi_sck = 1'b0; spi_mosi = 1'b0;
    set_status(4'b1010);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 reset", {spi_miso_oe, spi_miso}, 2'b00);

    // R1 R2 R4 R5 R6: ready, match, protected, 264-byte pages -> 8'hA6
    select_on();
    send_cmd(8'hD7);
    stream(3, -1, 0, 4'b0, "R1/R2/R4/R5/R6 word A6");
    select_off();

    // R9: busy, mismatch, unprotected, 256-byte pages -> 8'h65
    set_status(4'b0101);
    select_on();
    send_cmd(8'hD7);
    stream(2, -1, 0, 4'b0, "R9/R4/R6 busy word 65");
    select_off();

    // R3 R11: change in word 1 at bit 3; word 1 old, word 2 new
    set_status(4'b0001);
    select_on();
    send_cmd(8'hD7);
    stream(4, 1, 3, 4'b1110, "R3/R11 live reload");
    select_off();

    // R7: near-miss and unrelated command bytes
    select_on();
    send_cmd(8'hD6);
    silent(2);
    select_off();
    select_on();
    send_cmd(8'h53);
    silent(1);
    select_off();

    // R8: aborted after three bits, then a full query must still work
    select_on();
    do_bit(1'b1, 1'b0, 1'b0, 1'b0, "");
    do_bit(1'b1, 1'b0, 1'b0, 1'b0, "");
    do_bit(1'b0, 1'b0, 1'b0, 1'b0, "");
    select_off();
    set_status(4'b1011);
    select_on();
    send_cmd(8'hD7);
    stream(2, -1, 0, 4'b0, "R8 counter cleared");
    select_off();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule